// File: doc/BRIEF.md
# Weighted Constrained Request Generator

This block produces a stream of memory-access requests for a single processor port of a coherent cache model. Each request has a 32-bit address and a 2-bit operation code. The address is split into three fields. Each field is pseudo-random, but it is limited to an upper bound. A 3-bit setting picks that bound from a fixed table for the field. Four 8-bit weights set how often each of the four operations appears relative to the others. A test harness uses these settings to steer traffic toward conflicts in the address space.

A 32-bit linear-feedback shift register runs freely and supplies every random value. Software can reload it with a seed. When generation is enabled, the block registers one new request per cycle onto a valid/ready output. An offered request stays frozen until the consumer accepts it.

Top module: `stim_addr_gen`

## Requirements
- R1: While `rst_n` is low, `req_valid` is 0, `req_addr` is 0 and `req_op` is 0, and the random state becomes 32'h0000_0001.
- R2: The random state S updates on every rising edge. If `seed_load` is high, S takes `seed_val`, or 1 when `seed_val` is zero. Otherwise S shifts left by one bit, and the new bit 0 is the XOR of S bits 31, 21, 1 and 0.
- R3: Each captured request has tag `req_addr[31:16]` = S[31:16] mod (Tmax+1). S is the state just before the capturing edge. Tmax for `tag_sel` 0..7 is 0x1, 0x2, 0x4, 0x8, 0xF, 0xFF, 0xFFF, 0xFFFF.
- R4: The index `req_addr[15:4]` = S[15:4] mod (Imax+1). Imax for `idx_sel` 0..7 is 0x0, 0x1, 0x2, 0x4, 0x8, 0xF, 0xFF, 0xFFF.
- R5: The offset `req_addr[3:0]` = S[3:0] mod (Omax+1). Omax for `off_sel` 0..7 is 0x1, 0x2, 0x4, 0x8, 0xA, 0xB, 0xC, 0xF.
- R6: The operation codes are read=0, write=1, read-broadcast=2 and write-broadcast=3. The block forms the draw r = S[7:0] XOR S[31:24], the total T as the sum of the four weights, and v = (r*T)>>8. The operation is read if v < w_read, write if v < w_read+w_write, read-broadcast if v < w_read+w_write+w_rdbc, and write-broadcast otherwise.
- R7: When all four weights are zero, every captured request is a read (code 0).
- R8: An operation whose weight is zero is never issued, unless all four weights are zero.
- R9: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high and leaves `req_addr` and `req_op` unchanged.
- R10: When `enable` is high and the output is not held, a new request is captured and `req_valid` is 1 after the edge. When `enable` is low and the output is not held, `req_valid` is 0 after the edge.
- R11: Each captured field never exceeds the bound that its select input had at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load the random state from `seed_val` |
| seed_val | input | 32 | Seed value; zero is replaced by 1 |
| enable | input | 1 | Allow generation of new requests |
| tag_sel | input | 3 | Tag bound select |
| idx_sel | input | 3 | Index bound select |
| off_sel | input | 3 | Offset bound select |
| w_read | input | 8 | Relative weight of read |
| w_write | input | 8 | Relative weight of write |
| w_rdbc | input | 8 | Relative weight of read-broadcast |
| w_wrbc | input | 8 | Relative weight of write-broadcast |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Consumer accepts the offered request |
| req_addr | output | 32 | Request address |
| req_op | output | 2 | Request operation code |

## Verification
The bound and zero-weight assertions compare each captured request with the select and weight inputs as they were one cycle earlier. The hold property only applies when the consumer leaves ready low while valid is high. The stimulus changes settings only on falling edges, so every capture sees one stable set of values. It sweeps all eight codes of each select, several weight mixes including all-zero and single-zero cases, irregular ready stalls, enable gaps and a zero seed. A cycle model of the shift register predicts every address and operation exactly.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RBC = 2'd2,
    OP_WBC = 2'd3
  } sg_op_e;

  typedef enum logic [1:0] {
    FLD_TAG = 2'd0,
    FLD_IDX = 2'd1,
    FLD_OFF = 2'd2
  } sg_field_e;

  localparam int unsigned RNG_W = 32;

  // Taps 32,22,2,1 give a maximal-length sequence.
  function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
    return {s[RNG_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] tag_limit(input logic [2:0] k);
    case (k)
      3'd0: return 32'h0001;
      3'd1: return 32'h0002;
      3'd2: return 32'h0004;
      3'd3: return 32'h0008;
      3'd4: return 32'h000F;
      3'd5: return 32'h00FF;
      3'd6: return 32'h0FFF;
      default: return 32'hFFFF;
    endcase
  endfunction

  function automatic logic [31:0] idx_limit(input logic [2:0] k);
    case (k)
      3'd0: return 32'h000;
      3'd1: return 32'h001;
      3'd2: return 32'h002;
      3'd3: return 32'h004;
      3'd4: return 32'h008;
      3'd5: return 32'h00F;
      3'd6: return 32'h0FF;
      default: return 32'hFFF;
    endcase
  endfunction

  function automatic logic [31:0] off_limit(input logic [2:0] k);
    case (k)
      3'd0: return 32'h1;
      3'd1: return 32'h2;
      3'd2: return 32'h4;
      3'd3: return 32'h8;
      3'd4: return 32'hA;
      3'd5: return 32'hB;
      3'd6: return 32'hC;
      default: return 32'hF;
    endcase
  endfunction

endpackage

// File: rtl/sg_rng.sv
module sg_rng
  import sg_pkg::*;
#(
  parameter logic [RNG_W-1:0] RST_STATE = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [RNG_W-1:0] seed_val,
  output logic [RNG_W-1:0] state
);
  logic [RNG_W-1:0] seed_fixed;

  // An all-zero state would lock the register; replace it with 1.
  assign seed_fixed = (seed_val == '0) ? RNG_W'(1) : seed_val;

  always_ff @(posedge clk) begin
    if (!rst_n)         state <= RST_STATE;
    else if (seed_load) state <= seed_fixed;
    else                state <= rng_step(state);
  end
endmodule

// File: rtl/sg_field_bound.sv
module sg_field_bound
  import sg_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter sg_field_e   KIND = FLD_TAG
) (
  input  logic [W-1:0] raw,
  input  logic [2:0]   sel,
  output logic [W-1:0] val,
  output logic [W-1:0] lim
);
  localparam int unsigned SW = W + 1;

  logic [31:0]   lim_full;
  logic [SW-1:0] span;
  logic [SW-1:0] rem;

  generate
    if (KIND == FLD_TAG) begin : g_tag
      assign lim_full = tag_limit(sel);
    end else if (KIND == FLD_IDX) begin : g_idx
      assign lim_full = idx_limit(sel);
    end else begin : g_off
      assign lim_full = off_limit(sel);
    end
  endgenerate

  assign lim  = lim_full[W-1:0];
  assign span = {1'b0, lim} + SW'(1);
  assign rem  = {1'b0, raw} % span;
  assign val  = rem[W-1:0];
endmodule

// File: rtl/sg_op_pick.sv
module sg_op_pick
  import sg_pkg::*;
#(
  parameter int unsigned WGT_W  = 8,
  parameter int unsigned DRAW_W = 8
) (
  input  logic [WGT_W-1:0]  w_rd,
  input  logic [WGT_W-1:0]  w_wr,
  input  logic [WGT_W-1:0]  w_rb,
  input  logic [WGT_W-1:0]  w_wb,
  input  logic [DRAW_W-1:0] draw,
  output sg_op_e            op
);
  localparam int unsigned SUM_W  = WGT_W + 2;
  localparam int unsigned PROD_W = SUM_W + DRAW_W;

  logic [SUM_W-1:0]  cum0, cum1, cum2, total;
  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  pos;

  assign cum0  = SUM_W'(w_rd);
  assign cum1  = cum0 + SUM_W'(w_wr);
  assign cum2  = cum1 + SUM_W'(w_rb);
  assign total = cum2 + SUM_W'(w_wb);

  // Scale the draw into [0, total) so each weight owns its share.
  assign prod = PROD_W'(draw) * PROD_W'(total);
  assign pos  = prod[PROD_W-1:DRAW_W];

  always_comb begin
    if (total == '0)      op = OP_RD;
    else if (pos < cum0)  op = OP_RD;
    else if (pos < cum1)  op = OP_WR;
    else if (pos < cum2)  op = OP_RBC;
    else                  op = OP_WBC;
  end
endmodule

// File: rtl/stim_addr_gen.sv
module stim_addr_gen
  import sg_pkg::*;
#(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned WGT_W  = 8,
  parameter int unsigned DRAW_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            seed_load,
  input  logic [31:0]                     seed_val,
  input  logic                            enable,
  input  logic [2:0]                      tag_sel,
  input  logic [2:0]                      idx_sel,
  input  logic [2:0]                      off_sel,
  input  logic [WGT_W-1:0]                w_read,
  input  logic [WGT_W-1:0]                w_write,
  input  logic [WGT_W-1:0]                w_rdbc,
  input  logic [WGT_W-1:0]                w_wrbc,
  output logic                            req_valid,
  input  logic                            req_ready,
  output logic [TAG_W+IDX_W+OFF_W-1:0]    req_addr,
  output logic [1:0]                      req_op
);
  localparam int unsigned ADDR_W = TAG_W + IDX_W + OFF_W;

  logic [RNG_W-1:0]  rng_state;
  logic [TAG_W-1:0]  tag_v, tag_lim;
  logic [IDX_W-1:0]  idx_v, idx_lim;
  logic [OFF_W-1:0]  off_v, off_lim;
  logic [DRAW_W-1:0] draw;
  sg_op_e            op_pick;

  // Named events for the checker.
  logic hold_w;
  logic load_w;

  sg_rng u_rng (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .state     (rng_state)
  );

  sg_field_bound #(.W(TAG_W), .KIND(FLD_TAG)) u_tag (
    .raw (rng_state[ADDR_W-1 -: TAG_W]),
    .sel (tag_sel),
    .val (tag_v),
    .lim (tag_lim)
  );

  sg_field_bound #(.W(IDX_W), .KIND(FLD_IDX)) u_idx (
    .raw (rng_state[OFF_W +: IDX_W]),
    .sel (idx_sel),
    .val (idx_v),
    .lim (idx_lim)
  );

  sg_field_bound #(.W(OFF_W), .KIND(FLD_OFF)) u_off (
    .raw (rng_state[OFF_W-1:0]),
    .sel (off_sel),
    .val (off_v),
    .lim (off_lim)
  );

  assign draw = rng_state[DRAW_W-1:0] ^ rng_state[RNG_W-1 -: DRAW_W];

  sg_op_pick #(.WGT_W(WGT_W), .DRAW_W(DRAW_W)) u_op (
    .w_rd (w_read),
    .w_wr (w_write),
    .w_rb (w_rdbc),
    .w_wb (w_wrbc),
    .draw (draw),
    .op   (op_pick)
  );

  assign hold_w = req_valid && !req_ready;
  assign load_w = enable && !hold_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_op    <= OP_RD;
    end else if (load_w) begin
      req_valid <= 1'b1;
      req_addr  <= {tag_v, idx_v, off_v};
      req_op    <= op_pick;
    end else if (!hold_w) begin
      req_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_checker.sv
module sg_checker
  import sg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        load_w,
  input logic        hold_w,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic [1:0]  req_op,
  input logic [2:0]  tag_sel,
  input logic [2:0]  idx_sel,
  input logic [2:0]  off_sel,
  input logic [7:0]  w_read,
  input logic [7:0]  w_write,
  input logic [7:0]  w_rdbc,
  input logic [7:0]  w_wrbc
);
  logic all_zero;
  assign all_zero = (w_read == 8'd0) && (w_write == 8'd0) &&
                    (w_rdbc == 8'd0) && (w_wrbc == 8'd0);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w |=> req_valid && $stable(req_addr) && $stable(req_op));

  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> req_valid);

  a_r3_tag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> 32'(req_addr[31:16]) <= tag_limit($past(tag_sel)));

  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> 32'(req_addr[15:4]) <= idx_limit($past(idx_sel)));

  a_r5_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> 32'(req_addr[3:0]) <= off_limit($past(off_sel)));

  a_r7_all_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && all_zero) |=> req_op == OP_RD);

  a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && w_write == 8'd0) |=> req_op != OP_WR);

  a_r8_zero_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && w_rdbc == 8'd0 && w_wrbc == 8'd0) |=> req_op[1] == 1'b0);

  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && w_read == 8'd0 && !all_zero) |=> req_op != OP_RD);
endmodule

bind stim_addr_gen sg_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_w    (load_w),
  .hold_w    (hold_w),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .req_op    (req_op),
  .tag_sel   (tag_sel),
  .idx_sel   (idx_sel),
  .off_sel   (off_sel),
  .w_read    (w_read),
  .w_write   (w_write),
  .w_rdbc    (w_rdbc),
  .w_wrbc    (w_wrbc)
);

// File: tb/tb_stim_addr_gen.sv
module tb_stim_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [31:0] seed_val = '0;
  logic        enable = 1'b0;
  logic [2:0]  tag_sel = '0, idx_sel = '0, off_sel = '0;
  logic [7:0]  w_read = '0, w_write = '0, w_rdbc = '0, w_wrbc = '0;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [31:0] req_addr;
  logic [1:0]  req_op;

  always #5 clk = ~clk;

  stim_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .enable(enable), .tag_sel(tag_sel), .idx_sel(idx_sel), .off_sel(off_sel),
    .w_read(w_read), .w_write(w_write), .w_rdbc(w_rdbc), .w_wrbc(w_wrbc),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_op(req_op)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [31:0] m_s;
  logic        m_valid;
  logic [31:0] m_addr;
  logic [1:0]  m_op;

  function automatic longint t_max(int k);
    if (k < 4) return longint'(1) << k;
    return (longint'(1) << (4 * (k - 3))) - 1;
  endfunction

  function automatic longint i_max(int k);
    if (k == 0) return 0;
    if (k < 5) return longint'(1) << (k - 1);
    return (longint'(1) << (4 * (k - 4))) - 1;
  endfunction

  function automatic longint o_max(int k);
    if (k < 4) return longint'(1) << k;
    if (k < 7) return longint'(6 + k);
    return 15;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] s);
    return {s[30:0], ^(s & 32'h8020_0003)};
  endfunction

  function automatic logic [1:0] pick(logic [31:0] s);
    longint r, tot, v;
    r   = longint'(s[7:0] ^ s[31:24]);
    tot = longint'(w_read) + longint'(w_write) + longint'(w_rdbc) + longint'(w_wrbc);
    if (tot == 0) return 2'd0;
    v = (r * tot) / 256;
    if (v < longint'(w_read)) return 2'd0;
    if (v < longint'(w_read) + longint'(w_write)) return 2'd1;
    if (v < longint'(w_read) + longint'(w_write) + longint'(w_rdbc)) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [31:0] mk_addr(logic [31:0] s);
    longint t, i, o;
    t = longint'(s[31:16]) % (t_max(int'(tag_sel)) + 1);
    i = longint'(s[15:4])  % (i_max(int'(idx_sel)) + 1);
    o = longint'(s[3:0])   % (o_max(int'(off_sel)) + 1);
    return {t[15:0], i[11:0], o[3:0]};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One clock: inputs already applied at the falling edge.
  task automatic step(string optag);
    logic hold;
    @(posedge clk);
    hold = m_valid && !req_ready;
    if (!hold) begin
      if (enable) begin
        m_valid = 1'b1;
        m_addr  = mk_addr(m_s);
        m_op    = pick(m_s);
      end else begin
        m_valid = 1'b0;
      end
    end
    if (seed_load) m_s = (seed_val == 0) ? 32'd1 : seed_val;
    else           m_s = nxt(m_s);
    @(negedge clk);
    chk("R10 valid", 32'(req_valid), 32'(m_valid));
    if (m_valid) begin
      chk(hold ? "R9 addr held" : "R3/R4/R5 addr", req_addr, m_addr);
      chk(optag, 32'(req_op), 32'(m_op));
      if (!hold) begin
        chk("R11 tag bound", 32'(longint'(req_addr[31:16]) <= t_max(int'(tag_sel))), 32'd1);
        chk("R11 idx bound", 32'(longint'(req_addr[15:4]) <= i_max(int'(idx_sel))), 32'd1);
        chk("R11 off bound", 32'(longint'(req_addr[3:0]) <= o_max(int'(off_sel))), 32'd1);
      end
    end
  endtask

  task automatic set_w(int a, int b, int c, int d);
    w_read = 8'(a); w_write = 8'(b); w_rdbc = 8'(c); w_wrbc = 8'(d);
  endtask

  task automatic do_seed(logic [31:0] v);
    enable = 1'b0; seed_load = 1'b1; seed_val = v;
    step("R2 seed");
    seed_load = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", 32'(req_valid), 32'd0);
    chk("R1 addr", req_addr, 32'd0);
    chk("R1 op", 32'(req_op), 32'd0);
    rst_n = 1'b1;
    m_s = 32'd1; m_valid = 1'b0; m_addr = '0; m_op = '0;

    // R2: run from reset state, then seed
    set_w(25, 25, 25, 25);
    enable = 1'b1;
    repeat (8) step("R6 op");
    do_seed(32'h1234_5678);

    // R3 R4 R5 R6: all knobs together
    enable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tag_sel = 3'(k); idx_sel = 3'(k); off_sel = 3'(k);
      repeat (40) step("R6 op");
    end
    // Mixed knob combinations
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 8; j++) begin
        tag_sel = 3'(k); idx_sel = 3'(7 - j); off_sel = 3'(j);
        set_w(k * 30 + 1, j * 20, 255 - k * 30, j * 7);
        repeat (6) step("R6 op");
      end
    end

    // R7: all weights zero
    tag_sel = 3'd7; idx_sel = 3'd7; off_sel = 3'd7;
    set_w(0, 0, 0, 0);
    repeat (40) step("R7 op all-zero");
    // R8: zero weights never chosen
    set_w(0, 9, 0, 0);
    repeat (40) step("R8 op write only");
    set_w(0, 10, 0, 200);
    repeat (60) step("R8 op no read/rdbc");
    set_w(255, 0, 255, 0);
    repeat (60) step("R8 op no write/wrbc");
    set_w(1, 2, 3, 250);
    repeat (60) step("R6 op skewed");

    // R9: stalls
    set_w(40, 30, 20, 10);
    for (int c = 0; c < 90; c++) begin
      req_ready = ((c % 3) != 0) && ((c % 7) != 2);
      step("R9 op");
    end
    req_ready = 1'b1;

    // R10: enable gaps
    for (int c = 0; c < 60; c++) begin
      enable = ((c % 4) != 1) && ((c % 9) != 5);
      req_ready = (c % 5) != 0;
      step("R10 op");
    end
    req_ready = 1'b1;

    // R2: zero seed becomes 1
    do_seed(32'h0000_0000);
    enable = 1'b1;
    repeat (20) step("R2 op after zero seed");
    do_seed(32'hDEAD_BEEF);
    enable = 1'b1;
    repeat (20) step("R2 op after seed");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule